// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two page table entries from memory, one per level. A requester presents the virtual address together with two access attributes: whether the access writes, and whether it comes from user mode. The walker holds one request at a time. It fetches the top-level entry from a table whose frame is set by a loadable base register. If that entry allows the access, the walker fetches the second-level entry from the frame the first entry names. It then returns either the physical address or a fault code.

Both levels hold 1024 four-byte entries, and pages are 4 KB. The address splits into a 10-bit top index, a 10-bit second index and a 12-bit byte offset. Each entry has a valid flag, a write-permission flag, a user-permission flag and a 20-bit frame number. The walker checks validity and permission at each level. It stops at the first level that refuses the access. Memory is reached through a plain read port: a request handshake, then a single-cycle response some cycles later.

Top module: `ptw_top`

## Requirements
- R1: After reset, and whenever no walk is in progress, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The first memory read of a walk uses the address {base frame, vaddr[31:22], 2'b00}. The base frame is the register value at the moment the request is accepted.
- R3: The second memory read uses the address {first entry bits [31:12], vaddr[21:12], 2'b00}.
- R4: When a walk succeeds, `rsp_status` is 0 and `rsp_paddr` is {second entry bits [31:12], vaddr[11:0]}.
- R5: The entry format is: bit 0 valid, bit 1 write allowed, bit 2 user access allowed, bits [31:12] frame number. Bits [11:3] are ignored.
- R6: A first-level entry with bit 0 clear ends the walk after one memory read, with `rsp_status` 1 and `rsp_paddr` 0.
- R7: A second-level entry with bit 0 clear ends the walk with `rsp_status` 2 and `rsp_paddr` 0.
- R8: A valid entry at either level that forbids the access ends the walk with `rsp_status` 3 and `rsp_paddr` 0. The access is forbidden when it writes and bit 1 is clear, or when it comes from user mode and bit 2 is clear. A refusal at the first level issues no second read.
- R9: `req_ready` falls in the cycle after a request is accepted. It stays low until the cycle after the single-cycle `rsp_valid` pulse, and is high again in that following cycle.
- R10: A pulse on `base_load` writes `base_frame` into the base register. A walk already in progress keeps the base it captured when it was accepted, and later walks use the new value.
- R11: Once raised, `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. The walker has at most one memory read outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_load | input | 1 | Write `base_frame` into the table base register |
| base_frame | input | 20 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| rsp_valid | output | 1 | Single-cycle result pulse |
| rsp_status | output | 2 | 0 ok, 1 invalid at top level, 2 invalid at second level, 3 permission refused |
| rsp_paddr | output | 32 | Physical address, zero on any fault |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The walker is driven with accesses that differ only in their write and user attributes against the same pair of entries. This separates a permitted access from a refusal at the first level and from a refusal at the second level. Invalid entries placed at each level separate status 1 from status 2. The count of memory reads shows whether the walk stopped early. Addresses at index 0 and index 1023 cover the edges of the index fields. A base change made in the middle of a walk shows that the captured base is used. The memory model stalls its ready signal and varies its response delay to show that requests are held steady.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int LEVELS  = 2;
    localparam int PTE_W   = 32;
    localparam int FRAME_W = VA_W - OFF_W;
    localparam int ENT_B   = $clog2(PTE_W / 8);
    localparam int RSVD_W  = PTE_W - FRAME_W - 3;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [RSVD_W-1:0]  rsvd;
        logic               user_ok;
        logic               write_ok;
        logic               valid;
    } pte_t;

    typedef enum logic [1:0] {
        WS_OK      = 2'd0,
        WS_MISS_L1 = 2'd1,
        WS_MISS_L2 = 2'd2,
        WS_DENY    = 2'd3
    } walk_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_L1_REQ,
        S_L1_WAIT,
        S_L2_REQ,
        S_L2_WAIT,
        S_RESP
    } walk_state_e;

    typedef struct packed {
        logic [VA_W-1:0] vaddr;
        logic            write;
        logic            user;
    } walk_req_t;

    function automatic walk_status_e judge_entry(pte_t e, logic second,
                                                 logic write, logic user);
        if (!e.valid)
            return second ? WS_MISS_L2 : WS_MISS_L1;
        if ((write && !e.write_ok) || (user && !e.user_ok))
            return WS_DENY;
        return WS_OK;
    endfunction

endpackage

// File: rtl/ptw_entry_judge.sv
module ptw_entry_judge
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] entry,
    input  logic             second_level,
    input  logic             acc_write,
    input  logic             acc_user,
    output walk_status_e     verdict,
    output logic [FRAME_W-1:0] next_frame
);
    pte_t e;

    always_comb begin
        e          = pte_t'(entry);
        verdict    = judge_entry(e, second_level, acc_write, acc_user);
        next_frame = e.frame;
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 10,
    parameter int LEVELS  = 2,
    parameter int ENT_B   = 2,
    parameter int FRAME_W = VA_W - OFF_W,
    parameter int ADDR_W  = FRAME_W + IDX_W + ENT_B
) (
    input  logic [VA_W-1:0]    vaddr,
    input  logic [FRAME_W-1:0] table_frame,
    input  logic               second_level,
    output logic [ADDR_W-1:0]  entry_addr
);
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    logic [IDX_W-1:0] idx_by_level [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_by_level[g] = vaddr[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
    end

    logic [LVL_W-1:0] lvl;
    assign lvl = LVL_W'(second_level);

    assign entry_addr = {table_frame, idx_by_level[lvl], {ENT_B{1'b0}}};
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  walk_req_t          req_in,
    input  logic [FRAME_W-1:0] base_q,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  walk_status_e       verdict,
    input  logic [FRAME_W-1:0] next_frame,
    output logic               req_ready,
    output logic               mem_req_valid,
    output logic               second_level,
    output logic [FRAME_W-1:0] table_frame,
    output walk_req_t          cur_req,
    output logic               rsp_valid,
    output walk_status_e       rsp_status,
    output logic [VA_W-1:0]    rsp_paddr
);
    walk_state_e        state;
    walk_req_t          req_q;
    logic [FRAME_W-1:0] tbl_q;
    walk_status_e       st_q;
    logic [VA_W-1:0]    pa_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            req_q <= '0;
            tbl_q <= '0;
            st_q  <= WS_OK;
            pa_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        req_q <= req_in;
                        tbl_q <= base_q;
                        state <= S_L1_REQ;
                    end
                end
                S_L1_REQ: begin
                    if (mem_req_ready) state <= S_L1_WAIT;
                end
                S_L1_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (verdict != WS_OK) begin
                            st_q  <= verdict;
                            pa_q  <= '0;
                            state <= S_RESP;
                        end else begin
                            tbl_q <= next_frame;
                            state <= S_L2_REQ;
                        end
                    end
                end
                S_L2_REQ: begin
                    if (mem_req_ready) state <= S_L2_WAIT;
                end
                S_L2_WAIT: begin
                    if (mem_rsp_valid) begin
                        st_q  <= verdict;
                        pa_q  <= (verdict == WS_OK)
                                 ? {next_frame, req_q.vaddr[OFF_W-1:0]}
                                 : '0;
                        state <= S_RESP;
                    end
                end
                S_RESP: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready     = (state == S_IDLE);
        mem_req_valid = (state == S_L1_REQ) || (state == S_L2_REQ);
        second_level  = (state == S_L2_REQ) || (state == S_L2_WAIT);
        rsp_valid     = (state == S_RESP);
        table_frame   = tbl_q;
        cur_req       = req_q;
        rsp_status    = st_q;
        rsp_paddr     = pa_q;
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               base_load,
    input  logic [FRAME_W-1:0] base_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    input  logic               req_user,
    output logic               rsp_valid,
    output logic [1:0]         rsp_status,
    output logic [VA_W-1:0]    rsp_paddr,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [VA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [PTE_W-1:0]   mem_rsp_data
);
    logic [FRAME_W-1:0] base_q;
    logic [FRAME_W-1:0] table_frame;
    logic [FRAME_W-1:0] next_frame;
    logic               second_level;
    walk_req_t          req_in;
    walk_req_t          cur_req;
    walk_status_e       verdict;
    walk_status_e       status_e;

    always_ff @(posedge clk) begin
        if (rst)            base_q <= '0;
        else if (base_load) base_q <= base_frame;
    end

    assign req_in = '{vaddr: req_vaddr, write: req_write, user: req_user};

    ptw_ctrl ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_in        (req_in),
        .base_q        (base_q),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .verdict       (verdict),
        .next_frame    (next_frame),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .second_level  (second_level),
        .table_frame   (table_frame),
        .cur_req       (cur_req),
        .rsp_valid     (rsp_valid),
        .rsp_status    (status_e),
        .rsp_paddr     (rsp_paddr)
    );

    ptw_entry_judge judge_i (
        .entry        (mem_rsp_data),
        .second_level (second_level),
        .acc_write    (cur_req.write),
        .acc_user     (cur_req.user),
        .verdict      (verdict),
        .next_frame   (next_frame)
    );

    ptw_addr_gen #(
        .VA_W   (VA_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .LEVELS (LEVELS),
        .ENT_B  (ENT_B)
    ) addr_i (
        .vaddr        (cur_req.vaddr),
        .table_frame  (table_frame),
        .second_level (second_level),
        .entry_addr   (mem_req_addr)
    );

    assign rsp_status = status_e;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic [1:0]      rsp_status,
    input logic [VA_W-1:0] rsp_paddr,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [VA_W-1:0] mem_req_addr
);
    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst)                         off_q <= '0;
        else if (req_valid && req_ready) off_q <= req_vaddr[OFF_W-1:0];
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid);

    p_offset_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd0) |-> rsp_paddr[OFF_W-1:0] == off_q);

    p_fault_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 2'd0) |-> rsp_paddr == '0);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind ptw_top ptw_checker #(.VA_W(ptw_pkg::VA_W), .OFF_W(ptw_pkg::OFF_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_status    (rsp_status),
    .rsp_paddr     (rsp_paddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/ptw_top_tb.sv
module ptw_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_load = 1'b0;
    logic [19:0] base_frame = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_paddr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #2 clk = ~clk;

    ptw_top dut_i (.*);

    localparam logic [19:0] BASE_A = 20'h00010;
    localparam logic [19:0] BASE_B = 20'h00050;

    localparam int NMEM = 11;
    localparam logic [31:0] MEM_A [NMEM] = '{
        32'h0001_0004, 32'h0002_000C, 32'h0002_0010, 32'h0001_0008,
        32'h0003_0000, 32'h0001_0010, 32'h0005_0004, 32'h0006_000C,
        32'h0001_0FFC, 32'h0002_0FFC, 32'h0001_000C };
    localparam logic [31:0] MEM_D [NMEM] = '{
        32'h0002_0007, 32'h1234_5007, 32'h0AB0_0FF9, 32'h0003_0003,
        32'h0004_0007, 32'h0002_0005, 32'h0006_0007, 32'h7777_F007,
        32'h0002_0007, 32'h00AB_C007, 32'h0009_0006 };

    function automatic logic [31:0] mem_read(logic [31:0] a);
        for (int i = 0; i < NMEM; i++)
            if (MEM_A[i] == a) return MEM_D[i];
        return 32'h0;
    endfunction

    // memory model: stalls ready, one outstanding read, delay 1 or 2
    int          cyc = 0;
    int          rd_total = 0;
    logic [31:0] last_a = '0, prev_a = '0;
    logic        pend = 1'b0;
    int          pend_cnt = 0;
    logic [31:0] pend_a = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= (cyc % 3) != 1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            rd_total <= rd_total + 1;
            prev_a   <= last_a;
            last_a   <= mem_req_addr;
            pend     <= 1'b1;
            pend_a   <= mem_req_addr;
            pend_cnt <= (rd_total % 2);
        end else if (pend) begin
            if (pend_cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_read(pend_a);
                pend          <= 1'b0;
            end else begin
                pend_cnt <= pend_cnt - 1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_base(logic [19:0] f);
        @(negedge clk);
        base_load  = 1'b1;
        base_frame = f;
        @(negedge clk);
        base_load  = 1'b0;
    endtask

    logic [1:0]  got_st;
    logic [31:0] got_pa;
    int          got_rd;
    logic        got_busy_ok;

    task automatic walk(logic [31:0] va, logic wr, logic us, logic [19:0] mid_base, logic mid_load);
        int start_rd;
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        start_rd  = rd_total;
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        req_user  = us;
        @(negedge clk);
        req_valid = 1'b0;
        got_busy_ok = 1'b1;
        if (mid_load) begin
            base_load  = 1'b1;
            base_frame = mid_base;
        end
        n = 0;
        while (!rsp_valid && n < 500) begin
            if (req_ready) got_busy_ok = 1'b0;
            @(negedge clk);
            base_load = 1'b0;
            n++;
        end
        base_load = 1'b0;
        if (req_ready) got_busy_ok = 1'b0;
        got_st = rsp_status;
        got_pa = rsp_paddr;
        got_rd = rd_total - start_rd;
        @(negedge clk);
        check("R9 pulse ends", {30'b0, rsp_valid, req_ready}, 32'h1);
    endtask

    typedef struct packed {
        logic        use_b;
        logic [31:0] va;
        logic        wr;
        logic        us;
        logic [1:0]  st;
        logic [31:0] pa;
        logic [1:0]  nrd;
        logic [31:0] a1;
        logic [31:0] a2;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 32'h0040_3ABC, 1'b1, 1'b1, 2'd0, 32'h1234_5ABC, 2'd2, 32'h0001_0004, 32'h0002_000C},
        '{1'b0, 32'h0040_4123, 1'b0, 1'b0, 2'd0, 32'h0AB0_0123, 2'd2, 32'h0001_0004, 32'h0002_0010},
        '{1'b0, 32'h0040_4123, 1'b1, 1'b0, 2'd3, 32'h0,         2'd2, 32'h0001_0004, 32'h0002_0010},
        '{1'b0, 32'h0040_4123, 1'b0, 1'b1, 2'd3, 32'h0,         2'd2, 32'h0001_0004, 32'h0002_0010},
        '{1'b0, 32'h0040_5000, 1'b0, 1'b0, 2'd2, 32'h0,         2'd2, 32'h0001_0004, 32'h0002_0014},
        '{1'b0, 32'h00C0_0000, 1'b0, 1'b0, 2'd1, 32'h0,         2'd1, 32'h0001_000C, 32'h0},
        '{1'b0, 32'h0080_0123, 1'b0, 1'b1, 2'd3, 32'h0,         2'd1, 32'h0001_0008, 32'h0},
        '{1'b0, 32'h0080_0123, 1'b1, 1'b0, 2'd0, 32'h0004_0123, 2'd2, 32'h0001_0008, 32'h0003_0000},
        '{1'b0, 32'h0100_3456, 1'b1, 1'b1, 2'd3, 32'h0,         2'd1, 32'h0001_0010, 32'h0},
        '{1'b0, 32'h0100_3456, 1'b0, 1'b1, 2'd0, 32'h1234_5456, 2'd2, 32'h0001_0010, 32'h0002_000C},
        '{1'b0, 32'hFFFF_FFFF, 1'b0, 1'b1, 2'd0, 32'h00AB_CFFF, 2'd2, 32'h0001_0FFC, 32'h0002_0FFC},
        '{1'b0, 32'h0000_0000, 1'b0, 1'b0, 2'd1, 32'h0,         2'd1, 32'h0001_0000, 32'h0},
        '{1'b1, 32'h0040_3ABC, 1'b1, 1'b1, 2'd0, 32'h7777_FABC, 2'd2, 32'h0005_0004, 32'h0006_000C}
    };

    initial begin : watchdog
        while (cyc < 100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset ready/rsp/mem", {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

        // vector table: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            set_base(VEC[i].use_b ? BASE_B : BASE_A);
            walk(VEC[i].va, VEC[i].wr, VEC[i].us, 20'h0, 1'b0);
            check($sformatf("R4/R6/R7/R8 status v%0d", i), {30'b0, got_st}, {30'b0, VEC[i].st});
            check($sformatf("R4/R5 paddr v%0d", i), got_pa, VEC[i].pa);
            check($sformatf("R6/R8 read count v%0d", i), got_rd, {30'b0, VEC[i].nrd});
            if (VEC[i].nrd == 2'd2) begin
                check($sformatf("R2 level1 addr v%0d", i), prev_a, VEC[i].a1);
                check($sformatf("R3 level2 addr v%0d", i), last_a, VEC[i].a2);
            end else begin
                check($sformatf("R2 level1 addr v%0d", i), last_a, VEC[i].a1);
            end
            check($sformatf("R9 busy v%0d", i), {31'b0, got_busy_ok}, 32'h1);
        end

        // R10: base change during a walk does not affect it
        set_base(BASE_A);
        walk(32'h0040_3ABC, 1'b0, 1'b0, BASE_B, 1'b1);
        check("R10 in-flight keeps captured base", got_pa, 32'h1234_5ABC);
        walk(32'h0040_3ABC, 1'b0, 1'b0, 20'h0, 1'b0);
        check("R10 next walk uses new base", got_pa, 32'h7777_FABC);
        check("R10 R2 new base addr", prev_a, 32'h0005_0004);

        // R11 / R1: idle, no memory request
        repeat (4) @(negedge clk);
        check("R11 R1 idle no mem request", {31'b0, mem_req_valid}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule